// File: doc/BRIEF.md
# Link Power Status Monitor

This block tracks the power status line of a link-layer controller and sets the power mode of the interface between the PHY and that controller. A free-running internal clock samples the status line after a two-flop synchronizer. A counter measures how long the sampled line has stayed low without a break. Any high sample clears the count.

There are two thresholds, so the interface degrades in stages. A short low interval changes nothing, which lets an oscillating status signal count as present. A longer interval moves the interface to a low-power reset mode. In that mode the control and data outputs are forced to zero and incoming link requests are blocked, but the system clock keeps running. A still longer interval moves it to a disabled mode in which the system clock enable also drops.

The first high sample in either low-power mode brings the interface back to active. A link-active flag combines the line's status with a software control bit.

Top module: `link_power_monitor`

## Requirements
- R1: A high level on `lps_in` held for one clock period is seen as a high sample, and it clears any accumulated low count.
- R2: A run of at most `RST_TH` consecutive low samples, followed by a high sample, leaves `pwr_state` at active. An oscillating input with low runs that short therefore stays active.
- R3: Count rising edges from the first edge at which `lps_in` is low. With the line held low from the active state, `pwr_state` still reads active after `RST_TH+2` edges and reads reset after `RST_TH+3` edges. In reset, `out_force_zero` and `req_block` are 1 and `sysclk_en` is 1.
- R4: With the line still held low, `pwr_state` reads disabled after `DIS_TH+3` edges counted the same way, and `sysclk_en` is 0. Further low samples keep the disabled state.
- R5: While `rst_n` is low at a clock edge, the block goes to disabled: `sysclk_en` 0, `out_force_zero` 1, `req_block` 1, `link_active` 0.
- R6: `link_active` is 1 exactly when `pwr_state` is active and `link_ctrl` is 1.
- R7: From reset or disabled, a high on `lps_in` makes `pwr_state` read active three edges later, and `sysclk_en` is 1 in that same cycle.
- R8: `out_force_zero` and `req_block` fall one cycle after `pwr_state` becomes active. They rise in the same cycle that `pwr_state` leaves active.
- R9: `pwr_state` encoding: 2'b00 disabled, 2'b01 reset, 2'b10 active. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal sampling clock, never gated |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| lps_in | input | 1 | Link power status line, asynchronous |
| link_ctrl | input | 1 | Software link control bit |
| out_force_zero | output | 1 | Forces the control and data outputs to zero |
| req_block | output | 1 | Blocks incoming link requests |
| sysclk_en | output | 1 | Enable for the system clock output |
| link_active | output | 1 | Link is active (status present and control bit set) |
| pwr_state | output | 2 | Power mode: 00 disabled, 01 reset, 10 active |

## Verification
The line is held low long enough to cross each threshold, with the state read one edge before and one edge after each boundary. This separates off-by-one errors in the counter, the synchronizer and the thresholds. Low runs one sample under and one sample over the first threshold show whether an oscillating input is still taken as active. One-cycle high pulses out of both low-power modes test wake-up and the one-cycle lag on releasing the forcing. Random low and high runs with a random control bit are compared cycle by cycle against a bench model, which covers every state path and the link-active flag.

// File: rtl/lpm_pkg.sv
// Package: shared power-mode encoding for the link power status monitor.
// Assumes: the 2-bit encoding is visible on the top-level port.
package lpm_pkg;
    typedef enum logic [1:0] {
        PM_DISABLED = 2'b00,
        PM_RESET    = 2'b01,
        PM_ACTIVE   = 2'b10
    } pmode_t;
endpackage

// File: rtl/lpm_sync.sv
// Module: multi-stage synchronizer for one asynchronous level input.
// Assumes: the input is a level. One clock period of high is enough to be captured.
module lpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: capture the raw input into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                // Purpose: pass the level on to the next stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_low_counter.sv
// Module: counts consecutive low samples of the synchronized status line.
// Assumes: a high sample clears the count. The count saturates at DIS_TH.
module lpm_low_counter #(
    parameter int DIS_TH = 1280,
    parameter int CW     = $clog2(DIS_TH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_hi,
    output logic [CW-1:0] low_cnt
);
    localparam logic [CW-1:0] SAT = CW'(DIS_TH);

    // Purpose: clear on a high sample, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_cnt <= '0;
        else if (sample_hi)      low_cnt <= '0;
        else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
    end

    // R1: a high sample leaves the count at zero.
    p_clear_on_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hi |=> (low_cnt == '0));
    // R4: once saturated, further low samples hold the count.
    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_hi && low_cnt == SAT) |=> (low_cnt == SAT));
endmodule

// File: rtl/lpm_state_ctrl.sv
// Module: three-mode power state machine driven by the low-run count.
// Assumes: RST_TH < DIS_TH. The state changes on the sample that exceeds a threshold.
module lpm_state_ctrl
    import lpm_pkg::*;
#(
    parameter int RST_TH = 128,
    parameter int DIS_TH = 1280,
    parameter int CW     = $clog2(DIS_TH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_hi,
    input  logic [CW-1:0] low_cnt,
    output pmode_t        mode
);
    localparam logic [CW-1:0] RST_C = CW'(RST_TH);
    localparam logic [CW-1:0] DIS_C = CW'(DIS_TH);

    pmode_t mode_nxt;
    logic   past_dis;
    logic   past_rst;

    assign past_dis = !sample_hi && (low_cnt >= DIS_C);
    assign past_rst = !sample_hi && (low_cnt >= RST_C);

    // Purpose: choose the next mode from the current sample and the run length.
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            PM_ACTIVE: begin
                if (past_dis)      mode_nxt = PM_DISABLED;
                else if (past_rst) mode_nxt = PM_RESET;
            end
            PM_RESET: begin
                if (sample_hi)     mode_nxt = PM_ACTIVE;
                else if (past_dis) mode_nxt = PM_DISABLED;
            end
            PM_DISABLED: begin
                if (sample_hi)     mode_nxt = PM_ACTIVE;
            end
            default: mode_nxt = PM_DISABLED;
        endcase
    end

    // Purpose: hold the mode register. Hardware reset lands in disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= PM_DISABLED;
        else        mode <= mode_nxt;
    end

    // R7: any high sample brings the interface to active on the next cycle.
    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hi |=> (mode == PM_ACTIVE));
    // R3: the low sample that exceeds RST_TH moves active to reset.
    p_enter_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_ACTIVE && !sample_hi && low_cnt == RST_C) |=> (mode == PM_RESET));
    // R9: the unused code never appears.
    p_legal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);
endmodule

// File: rtl/lpm_out_gate.sv
// Module: derives the interface gating outputs from the power mode.
// Assumes: forcing rises as soon as the mode leaves active and falls one cycle after it returns.
module lpm_out_gate
    import lpm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  pmode_t mode,
    input  logic   link_ctrl,
    output logic   force_zero,
    output logic   block_req,
    output logic   clk_en,
    output logic   link_on
);
    logic was_active_q;

    // Purpose: remember whether the previous cycle was already active.
    always_ff @(posedge clk) begin
        if (!rst_n) was_active_q <= 1'b0;
        else        was_active_q <= (mode == PM_ACTIVE);
    end

    // Purpose: combine the mode and its one-cycle history into the gate outputs.
    always_comb begin
        force_zero = !((mode == PM_ACTIVE) && was_active_q);
        block_req  = force_zero;
        clk_en     = (mode != PM_DISABLED);
        link_on    = (mode == PM_ACTIVE) && link_ctrl;
    end

    // R8: forcing is still in place in the first active cycle.
    p_release_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == PM_ACTIVE) |-> force_zero);
    // R3: outside active, both gates are closed.
    p_gated_when_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_ACTIVE) |-> (force_zero && block_req));
endmodule

// File: rtl/link_power_monitor.sv
// Module: top of the link power status monitor. Synchronizes the status line,
// measures low runs and drives the PHY-to-link interface power gating.
// Assumes: clk is free-running and never gated. RST_TH < DIS_TH.
module link_power_monitor
    import lpm_pkg::*;
#(
    parameter int RST_TH      = 128,
    parameter int DIS_TH      = 1280,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lps_in,
    input  logic       link_ctrl,
    output logic       out_force_zero,
    output logic       req_block,
    output logic       sysclk_en,
    output logic       link_active,
    output logic [1:0] pwr_state
);
    localparam int CW = $clog2(DIS_TH + 1);

    logic          sample_hi;
    logic [CW-1:0] low_cnt;
    pmode_t        mode;

    lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lps_in),
        .dout  (sample_hi)
    );

    lpm_low_counter #(.DIS_TH(DIS_TH), .CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_hi (sample_hi),
        .low_cnt   (low_cnt)
    );

    lpm_state_ctrl #(.RST_TH(RST_TH), .DIS_TH(DIS_TH), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_hi (sample_hi),
        .low_cnt   (low_cnt),
        .mode      (mode)
    );

    lpm_out_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .link_ctrl  (link_ctrl),
        .force_zero (out_force_zero),
        .block_req  (req_block),
        .clk_en     (sysclk_en),
        .link_on    (link_active)
    );

    assign pwr_state = mode;

    // R4: in the disabled mode the system clock enable is off.
    p_no_clk_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b00) |-> !sysclk_en);
    // R6: the link-active flag never rises while the control bit is clear.
    p_link_needs_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_active |-> link_ctrl);
endmodule

// File: tb/link_power_monitor_bench.sv
module link_power_monitor_bench;
    localparam int RST_TH = 8;
    localparam int DIS_TH = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lps_in = 1'b0;
    logic       link_ctrl = 1'b0;
    logic       out_force_zero, req_block, sysclk_en, link_active;
    logic [1:0] pwr_state;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    link_power_monitor #(.RST_TH(RST_TH), .DIS_TH(DIS_TH)) u_link_power_monitor (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .link_ctrl(link_ctrl),
        .out_force_zero(out_force_zero), .req_block(req_block),
        .sysclk_en(sysclk_en), .link_active(link_active), .pwr_state(pwr_state)
    );

    // Bench model of the requirements: two-edge input latency, run-length rules.
    logic       m1 = 1'b0, m2 = 1'b0, m_was = 1'b0;
    int         m_run = 0;
    logic [1:0] m_st = 2'b00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 <= 1'b0; m2 <= 1'b0; m_run <= 0; m_st <= 2'b00; m_was <= 1'b0;
        end else begin
            m1 <= lps_in;
            m2 <= m1;
            m_was <= (m_st == 2'b10);
            if (m2) begin
                m_run <= 0;
                m_st  <= 2'b10;
            end else begin
                m_run <= m_run + 1;
                if (m_run + 1 > DIS_TH)                      m_st <= 2'b00;
                else if (m_run + 1 > RST_TH && m_st == 2'b10) m_st <= 2'b01;
            end
        end
    end

    function automatic logic exp_force(logic [1:0] st, logic was);
        return !(st == 2'b10 && was);
    endfunction

    function automatic logic exp_link(logic [1:0] st, logic ctl);
        return (st == 2'b10) && ctl;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Model comparison on every falling edge while enabled.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check("R9 state vs model", {6'd0, pwr_state}, {6'd0, m_st});
            check("R8 force vs model", {7'd0, out_force_zero}, {7'd0, exp_force(m_st, m_was)});
            check("R8 block vs model", {7'd0, req_block}, {7'd0, exp_force(m_st, m_was)});
            check("R4 clk_en vs model", {7'd0, sysclk_en}, {7'd0, m_st != 2'b00});
            check("R6 link vs model", {7'd0, link_active}, {7'd0, exp_link(m_st, link_ctrl)});
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            finish_run();
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd7);
        // R5: hardware reset lands in disabled.
        lps_in = 1'b1; link_ctrl = 1'b1;
        edges(3);
        check("R5 reset state", {6'd0, pwr_state}, 8'h00);
        check("R5 reset clk_en", {7'd0, sysclk_en}, 8'h0);
        check("R5 reset force", {7'd0, out_force_zero}, 8'h1);
        check("R5 reset block", {7'd0, req_block}, 8'h1);
        check("R5 reset link", {7'd0, link_active}, 8'h0);
        rst_n = 1'b1;
        // R7: wake from disabled, three edges, clock enable at once.
        edges(2);
        check("R7 not yet active", {6'd0, pwr_state}, 8'h00);
        edges(1);
        check("R7 active after 3", {6'd0, pwr_state}, 8'h02);
        check("R7 clk_en with state", {7'd0, sysclk_en}, 8'h1);
        check("R8 force lag", {7'd0, out_force_zero}, 8'h1);
        edges(1);
        check("R8 force released", {7'd0, out_force_zero}, 8'h0);
        check("R6 link with ctrl", {7'd0, link_active}, 8'h1);
        link_ctrl = 1'b0; edges(1);
        check("R6 link without ctrl", {7'd0, link_active}, 8'h0);
        link_ctrl = 1'b1;
        // R2: RST_TH low samples then high stays active.
        lps_in = 1'b0; edges(RST_TH); lps_in = 1'b1; edges(4);
        check("R2 short low stays active", {6'd0, pwr_state}, 8'h02);
        check("R2 no forcing", {7'd0, out_force_zero}, 8'h0);
        // R3: boundary into reset mode.
        lps_in = 1'b0;
        edges(RST_TH + 2);
        check("R3 still active at edge RST_TH+2", {6'd0, pwr_state}, 8'h02);
        edges(1);
        check("R3 reset at edge RST_TH+3", {6'd0, pwr_state}, 8'h01);
        check("R3 force in reset", {7'd0, out_force_zero}, 8'h1);
        check("R3 block in reset", {7'd0, req_block}, 8'h1);
        check("R3 clock kept in reset", {7'd0, sysclk_en}, 8'h1);
        check("R6 link off in reset", {7'd0, link_active}, 8'h0);
        // R4: boundary into disabled.
        edges(DIS_TH - RST_TH - 1);
        check("R4 still reset at edge DIS_TH+2", {6'd0, pwr_state}, 8'h01);
        edges(1);
        check("R4 disabled at edge DIS_TH+3", {6'd0, pwr_state}, 8'h00);
        check("R4 clock off", {7'd0, sysclk_en}, 8'h0);
        edges(20);
        check("R4 stays disabled", {6'd0, pwr_state}, 8'h00);
        // R1: a one-period high pulse wakes the block and clears the run.
        lps_in = 1'b1; edges(1); lps_in = 1'b0;
        edges(2);
        check("R1 pulse wakes", {6'd0, pwr_state}, 8'h02);
        edges(RST_TH);
        check("R1 run restarted", {6'd0, pwr_state}, 8'h02);
        edges(1);
        check("R1 reset after fresh run", {6'd0, pwr_state}, 8'h01);
        // R7: wake from reset mode.
        lps_in = 1'b1; edges(3);
        check("R7 wake from reset", {6'd0, pwr_state}, 8'h02);
        // Random runs checked against the model.
        model_on = 1'b1;
        for (int p = 0; p < 300; p++) begin
            lps_in = 1'b0;
            edges($urandom_range(0, DIS_TH + 15));
            lps_in = 1'b1;
            if ($urandom_range(0, 3) == 0) link_ctrl = ~link_ctrl;
            edges($urandom_range(1, 4));
        end
        model_on = 1'b0;
        finish_run();
    end
endmodule